// File: doc/BRIEF.md
# Vectored Interrupt Enable Controller

This block sits between the interrupt flags of a small 8-bit controller's peripherals and its CPU core. It has six request sources: two external lines, three timers and a serial port. The serial source is the OR of a receive flag and a transmit flag. The third timer's source is the OR of an overflow flag and an external-capture flag. Each source is gated by its own bit in a byte-wide enable register, and a master bit sits above all the per-source bits. Software writes and reads this register through a simple byte port.

When at least one gated request is pending and the core is not already being served, the block takes the highest-priority source. It raises a request strobe and presents that source's fixed code address. Strobe and address stay frozen until the core acknowledges. The strobe is then low for one cycle, and the block looks again at whatever is pending.

The block also supplies the restart address. This is 0000h when the first code byte is programmed. It is a parameterised boot-loader entry address when that byte reads FFh, meaning it has been erased.

Top module: `ic_vector_ctrl`

## Requirements
- R1: After a synchronous reset, `reg_rd_data` reads 00h, `irq_req` is 0 and `irq_vector` is 0000h.
- R2: While enable bit 7 (master) is 0, `irq_req` never rises, whatever the other enable bits and the flags hold.
- R3: With bit 7 set, a source can raise a request only if its own enable bit is set: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2.
- R4: A write with `reg_wr_en` high loads `reg_wr_data` on the clock edge, and `reg_rd_data` shows it from the next cycle. Bit 6 always reads 0, and writes to it are ignored.
- R5: The vector addresses are 0003h for external 0, 000Bh for timer 0, 0013h for external 1, 001Bh for timer 1, 0023h for serial and 002Bh for timer 2.
- R6: When several gated requests are pending, the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial, timer 2, with external 0 highest.
- R7: The serial request is `ser_rx_flag | ser_tx_flag`. The timer-2 request is `tmr2_ovf_flag | tmr2_ext_flag`.
- R8: From the edge after the pending request is seen, `irq_req` is 1. Until `irq_ack` is sampled high, `irq_req` and `irq_vector` stay unchanged, even if the flags or the enables change. An `irq_ack` while `irq_req` is 0 has no effect.
- R9: The edge that samples `irq_ack` high with `irq_req` high drives `irq_req` to 0. The next edge re-evaluates the pending requests.
- R10: `reset_vector` is 0000h unless `boot_byte` is FFh. In that case it is the parameter `ISP_ENTRY` (default F000h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Enable-register write strobe |
| reg_wr_data | input | 8 | Enable-register write data |
| reg_rd_data | output | 8 | Enable-register read data |
| ext0_flag | input | 1 | External line 0 flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External line 1 flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external flag |
| irq_ack | input | 1 | Core acknowledge |
| boot_byte | input | 8 | Code byte stored at address 0000h |
| irq_req | output | 1 | Interrupt request strobe |
| irq_vector | output | 16 | Vector of the request being presented |
| reset_vector | output | 16 | Restart address |

## Verification
Two things can fall in the same cycle: the acknowledge of a held request and the arrival of a new pending request (or of an enable write). The bench provokes this by keeping flags asserted across the acknowledge, and in random rounds by changing flags and enables while a request is held. Judging covers three points. The held vector must not move. The strobe must drop for exactly the cycle after the acknowledge. The next strobe must carry the vector that a bench model computes from the flags and enables at that moment.

// File: rtl/ic_vec_pkg.sv
package ic_vec_pkg;

    localparam int NUM_SRC   = 6;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    localparam int REG_W     = 8;
    localparam int RSVD_BIT  = 6;
    localparam int MASTER_BIT = 7;
    localparam int VEC_STRIDE = 8;
    localparam int VEC_OFFSET = 3;

    typedef enum logic [SRC_IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } src_e;

    typedef struct packed {
        logic ext0;
        logic tmr0;
        logic ext1;
        logic tmr1;
        logic ser_rx;
        logic ser_tx;
        logic t2_ovf;
        logic t2_ext;
    } raw_flags_t;

    typedef struct packed {
        logic master;
        logic rsvd;
        logic tmr2;
        logic ser;
        logic tmr1;
        logic ext1;
        logic tmr0;
        logic ext0;
    } en_reg_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic logic [NUM_SRC-1:0] merge_flags(raw_flags_t f);
        logic [NUM_SRC-1:0] m;
        m[SRC_EXT0] = f.ext0;
        m[SRC_TMR0] = f.tmr0;
        m[SRC_EXT1] = f.ext1;
        m[SRC_TMR1] = f.tmr1;
        m[SRC_SER]  = f.ser_rx | f.ser_tx;
        m[SRC_TMR2] = f.t2_ovf | f.t2_ext;
        return m;
    endfunction

    function automatic logic [15:0] vector_of(src_e s);
        return 16'(int'(s) * VEC_STRIDE + VEC_OFFSET);
    endfunction

    function automatic logic [REG_W-1:0] clean_write(logic [REG_W-1:0] d);
        logic [REG_W-1:0] r;
        r = d;
        r[RSVD_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ic_req_gate.sv
module ic_req_gate
    import ic_vec_pkg::*;
(
    input  raw_flags_t         flags,
    input  en_reg_t            en,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] merged;
    logic [REG_W-1:0]   en_bits;

    assign merged  = merge_flags(flags);
    assign en_bits = en;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        assign pend[i] = merged[i] & en_bits[i] & en.master;
    end

    logic unused_rsvd;
    assign unused_rsvd = en.rsvd;
endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick
    import ic_vec_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output pick_t              pick
);
    always_comb begin
        pick.valid = 1'b0;
        pick.src   = SRC_EXT0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick.valid = 1'b1;
                pick.src   = src_e'(i[SRC_IDX_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/ic_vec_hold.sv
module ic_vec_hold
    import ic_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pick_t       pick,
    input  logic        ack,
    output logic        req,
    output logic [15:0] vector
);
    logic        req_q;
    logic [15:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else if (req_q) begin
            if (ack) req_q <= 1'b0;
        end else if (pick.valid) begin
            req_q <= 1'b1;
            vec_q <= vector_of(pick.src);
        end
    end

    assign req    = req_q;
    assign vector = vec_q;
endmodule

// File: rtl/ic_vector_ctrl.sv
module ic_vector_ctrl
    import ic_vec_pkg::*;
#(
    parameter logic [15:0] ISP_ENTRY = 16'hF000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  reg_rd_data,
    input  logic        ext0_flag,
    input  logic        tmr0_flag,
    input  logic        ext1_flag,
    input  logic        tmr1_flag,
    input  logic        ser_rx_flag,
    input  logic        ser_tx_flag,
    input  logic        tmr2_ovf_flag,
    input  logic        tmr2_ext_flag,
    input  logic        irq_ack,
    input  logic [7:0]  boot_byte,
    output logic        irq_req,
    output logic [15:0] irq_vector,
    output logic [15:0] reset_vector
);
    localparam logic [7:0] ERASED = 8'hFF;

    en_reg_t            en_q;
    raw_flags_t         flags;
    logic [NUM_SRC-1:0] pend;
    pick_t              pick;

    always_ff @(posedge clk) begin
        if (rst)            en_q <= '0;
        else if (reg_wr_en) en_q <= en_reg_t'(clean_write(reg_wr_data));
    end

    assign reg_rd_data = en_q;

    assign flags = '{ext0: ext0_flag, tmr0: tmr0_flag, ext1: ext1_flag,
                     tmr1: tmr1_flag, ser_rx: ser_rx_flag, ser_tx: ser_tx_flag,
                     t2_ovf: tmr2_ovf_flag, t2_ext: tmr2_ext_flag};

    ic_req_gate u_gate (.flags(flags), .en(en_q), .pend(pend));
    ic_prio_pick u_pick (.pend(pend), .pick(pick));
    ic_vec_hold u_hold (
        .clk(clk), .rst(rst), .pick(pick), .ack(irq_ack),
        .req(irq_req), .vector(irq_vector)
    );

    assign reset_vector = (boot_byte == ERASED) ? ISP_ENTRY : 16'h0000;
endmodule

// File: rtl/ic_vector_ctrl_chk.sv
module ic_vector_ctrl_chk #(
    parameter logic [15:0] ISP_ENTRY = 16'hF000
) (
    input logic        clk,
    input logic        rst,
    input logic        irq_req,
    input logic        irq_ack,
    input logic [15:0] irq_vector,
    input logic [7:0]  reg_rd_data,
    input logic [7:0]  boot_byte,
    input logic [15:0] reset_vector
);
    a_r2_master_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(reg_rd_data[7]));

    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[6] == 1'b0);

    a_r5_vector_map: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector < 16'h0030));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector)));

    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    a_r10_boot_entry: assert property (@(posedge clk) disable iff (rst)
        reset_vector == ((boot_byte == 8'hFF) ? ISP_ENTRY : 16'h0000));
endmodule

bind ic_vector_ctrl ic_vector_ctrl_chk #(.ISP_ENTRY(ISP_ENTRY)) chk_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_vector(irq_vector), .reg_rd_data(reg_rd_data),
    .boot_byte(boot_byte), .reset_vector(reset_vector)
);

// File: tb/ic_vector_ctrl_tb_top.sv
module ic_vector_ctrl_tb_top;
    localparam logic [15:0] ISP = 16'hF000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  fl = '0;
    logic        ack = 1'b0;
    logic [7:0]  boot = 8'h00;
    logic        req;
    logic [15:0] vec;
    logic [15:0] rvec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ic_vector_ctrl #(.ISP_ENTRY(ISP)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_wr_data(wdata),
        .reg_rd_data(rdata), .ext0_flag(fl[0]), .tmr0_flag(fl[1]),
        .ext1_flag(fl[2]), .tmr1_flag(fl[3]), .ser_rx_flag(fl[4]),
        .ser_tx_flag(fl[5]), .tmr2_ovf_flag(fl[6]), .tmr2_ext_flag(fl[7]),
        .irq_ack(ack), .boot_byte(boot), .irq_req(req),
        .irq_vector(vec), .reset_vector(rvec)
    );

    // Model: returns 0 when nothing is pending, else the expected vector.
    function automatic logic [15:0] model_vec(logic [7:0] en, logic [7:0] f);
        logic [5:0] m;
        m = {f[6] | f[7], f[4] | f[5], f[3], f[2], f[1], f[0]};
        if (!en[7]) return 16'h0000;
        for (int i = 0; i < 6; i++)
            if (m[i] && en[i]) return 16'(8 * i + 3);
        return 16'h0000;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_en(logic [7:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    // Acknowledge the held request, check the drop, then leave idle.
    task automatic ack_clear();
        ack = 1'b1;
        @(negedge clk);
        chk("R9 strobe drops after ack", {31'd0, req}, 32'd0);
        ack = 1'b0; fl = '0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] e;
        logic [15:0] held;
        logic [7:0]  en;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset reg", {24'd0, rdata}, 32'h00);
        chk("R1 reset req", {31'd0, req}, 32'd0);
        chk("R1 reset vector", {16'd0, vec}, 32'h0000);

        // R4: write/readback, reserved bit forced to 0
        wr_en(8'hFF);
        chk("R4 readback rsvd", {24'd0, rdata}, 32'hBF);
        wr_en(8'h40);
        chk("R4 rsvd only write", {24'd0, rdata}, 32'h00);

        // R2: master off blocks everything
        wr_en(8'h3F); fl = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R2 master off", {31'd0, req}, 32'd0);
        fl = '0;

        // R6 + R9: all pending, priority walk with re-evaluation
        wr_en(8'hBF); fl = 8'hFF;
        @(negedge clk);
        chk("R6 top priority", {16'd0, vec}, 32'h0003);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R9 gap cycle", {31'd0, req}, 32'd0);
        fl[0] = 1'b0;
        @(negedge clk);
        chk("R9 re-evaluate", {31'd0, req}, 32'd1);
        chk("R6 next priority", {16'd0, vec}, 32'h000B);
        ack_clear();

        // R3: per-source gating, only timer 1 enabled
        wr_en(8'h88); fl = 8'h07;
        repeat (2) @(negedge clk);
        chk("R3 disabled sources", {31'd0, req}, 32'd0);
        fl = 8'h0F;
        @(negedge clk);
        chk("R3 enabled source", {16'd0, vec}, 32'h001B);
        ack_clear();

        // R7: OR-merged flags
        wr_en(8'h90); fl = 8'h20;
        @(negedge clk);
        chk("R7 serial tx", {16'd0, vec}, 32'h0023);
        ack_clear();
        fl = 8'h10;
        @(negedge clk);
        chk("R7 serial rx", {16'd0, vec}, 32'h0023);
        ack_clear();
        wr_en(8'hA0); fl = 8'h80;
        @(negedge clk);
        chk("R7 timer2 ext", {16'd0, vec}, 32'h002B);
        ack_clear();
        fl = 8'h40;
        @(negedge clk);
        chk("R5 timer2 vector via ovf", {16'd0, vec}, 32'h002B);
        ack_clear();

        // R8: ack while idle ignored; hold against flag/enable changes
        wr_en(8'h84);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0; fl = 8'h04;
        @(negedge clk);
        chk("R8 idle ack ignored", {31'd0, req}, 32'd1);
        fl = 8'h01; wr_en(8'h81);
        chk("R8 hold vector", {16'd0, vec}, 32'h0013);
        chk("R8 hold strobe", {31'd0, req}, 32'd1);
        ack_clear();

        // R10: restart address
        boot = 8'hFF; #1;
        chk("R10 erased byte", {16'd0, rvec}, {16'd0, ISP});
        boot = 8'hFE; #1;
        chk("R10 programmed byte", {16'd0, rvec}, 32'h0000);
        boot = 8'h02; #1;
        chk("R10 programmed byte 2", {16'd0, rvec}, 32'h0000);

        // Random rounds, R5/R6 against the model
        for (int n = 0; n < 400; n++) begin
            en = 8'($urandom());
            wr_en(en);
            fl = 8'($urandom());
            en[6] = 1'b0;
            e = model_vec(en, fl);
            @(negedge clk);
            chk("R3 random strobe", {31'd0, req}, {31'd0, e != 16'h0000});
            if (e != 16'h0000) begin
                chk("R5 random vector", {16'd0, vec}, {16'd0, e});
                held = e;
                for (int k = 0; k < int'($urandom_range(3, 0)); k++) begin
                    fl = 8'($urandom());
                    @(negedge clk);
                    chk("R8 random hold", {16'd0, vec}, {16'd0, held});
                end
                ack_clear();
            end else begin
                fl = '0;
            end
        end

        finish_run();
    end
endmodule